// File: doc/BRIEF.md
# Banked Integer Matrix Multiplier

This block computes the product C = A × B of two square signed integer matrices whose size is fixed at elaboration by the parameter `DIM`. A `start` pulse opens a job. The block then takes 2·DIM² words from one valid/ready input stream. The first DIM² words are A and the next DIM² words are B, each sent one row after another, starting at the top-left element.

Operand storage is split into DIM banks. Bank k holds column k of A and row k of B. This lets one cycle read a whole row of A and a whole column of B. After loading, the block issues one output element per cycle, row by row. Each element goes through DIM parallel multipliers and a registered binary adder tree, and the result is written into an on-chip result buffer.

When every element has been computed, the buffer is drained row by row on a valid/ready output stream. A one-cycle `done` pulse marks the end of the job. Smaller problems are handled by the host, which pads its matrices with zeros up to DIM×DIM.

Top module: `mat_mul_buf`

## Requirements
- R1: While reset is held and after it is released, before any start: `in_ready`, `out_valid`, `done` and `busy` are 0.
- R2: A `start` pulse while idle makes `busy` and `in_ready` high from the next cycle on.
- R3: Accepted input words (cycles with `in_valid` and `in_ready` both high) fill A row-major, then B row-major. Cycles with `in_valid` low are not taken. `in_ready` is 0 from the cycle after the 2·DIM²-th word is accepted, and `in_ready` is never high together with `out_valid`.
- R4: The output stream carries exactly DIM² words, C[0][0], C[0][1], …, C[DIM-1][DIM-1]. Each word is the signed sum over k of A[r][k]·B[k][c], in two's complement with AW = 2·DW + ceil(log2 DIM) bits.
- R5: `out_valid` first rises exactly DIM² + ceil(log2 DIM) + 1 cycles after the clock edge that accepts the last B word.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R7: `done` is high for exactly the one cycle after the last result word is accepted. In that cycle `busy` is 0. While idle, `in_ready` and `out_valid` are 0.
- R8: When A and B are n×n matrices (n < DIM) padded with zeros, the top-left n×n of the output is their product and every other output word is 0.
- R9: A `start` pulse while busy has no effect on the job in progress.
- R10: All-most-negative operands (−2^(DW−1) in every element) give DIM·2^(2·DW−2) in every result word, without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (honoured only while idle) |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block takes input words (load phases) |
| in_data | input | DW | Signed operand word |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | AW | Signed result word |
| done | output | 1 | One-cycle pulse after the last result is taken |
| busy | output | 1 | A job is in progress |

## Verification
The latency of the block is fixed by its structure. The bench counts clock edges from the one that accepts the last B word and expects `out_valid` to appear at edge DIM² + ceil(log2 DIM) + 1, which is 68 for DIM = 8. That count covers DIM² issue cycles, one product register, the tree levels, and the buffer write.

All inputs are driven and all outputs sampled at the falling edge, so a value seen there is the one the next rising edge acts on. `in_ready` is checked at the first falling edge after the final load, and each output word is compared at the falling edge just before the rising edge that takes it. `done` is checked one falling edge after the last output handshake and again one edge later, to confirm it lasts a single cycle.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LOAD_A  = 3'd1,
    PH_LOAD_B  = 3'd2,
    PH_COMPUTE = 3'd3,
    PH_STORE   = 3'd4
  } phase_e;

  // Index width for a dimension, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mm_bank.sv
// One operand bank: column k of A and row k of B, one write and two reads.
module mm_bank #(
  parameter int DIM = 8,
  parameter int DW  = 16,
  localparam int IW = mm_pkg::idx_w(DIM)
) (
  input  logic                 clk,
  input  logic                 a_we,
  input  logic                 b_we,
  input  logic [IW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [IW-1:0]        a_raddr,
  input  logic [IW-1:0]        b_raddr,
  output logic signed [DW-1:0] a_rdata,
  output logic signed [DW-1:0] b_rdata
);

  logic signed [DW-1:0] a_col [DIM];
  logic signed [DW-1:0] b_row [DIM];

  always_ff @(posedge clk) begin
    if (a_we) a_col[waddr] <= wdata;
    if (b_we) b_row[waddr] <= wdata;
  end

  assign a_rdata = a_col[a_raddr];
  assign b_rdata = b_row[b_raddr];

endmodule

// File: rtl/mm_adder_tree.sv
// DIM parallel multipliers feeding a registered binary tree (heap indexed).
module mm_adder_tree #(
  parameter int DIM = 8,
  parameter int DW  = 16,
  parameter int AW  = 35,
  parameter int TW  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [TW-1:0]        in_tag,
  input  logic signed [DW-1:0] a_vec [DIM],
  input  logic signed [DW-1:0] b_vec [DIM],
  output logic                 out_valid,
  output logic [TW-1:0]        out_tag,
  output logic signed [AW-1:0] out_sum
);

  localparam int LVL = (DIM > 1) ? $clog2(DIM) : 0;
  localparam int P   = 1 << LVL;

  logic signed [AW-1:0] node [1:2*P-1];
  logic [LVL:0]         v_q;
  logic [TW-1:0]        t_q [LVL+1];

  generate
    for (genvar k = 0; k < P; k++) begin : g_leaf
      if (k < DIM) begin : g_mul
        logic signed [2*DW-1:0] prod;
        assign prod = a_vec[k] * b_vec[k];
        always_ff @(posedge clk) begin
          if (in_valid) node[P+k] <= AW'(prod);
        end
      end else begin : g_pad
        always_ff @(posedge clk) begin
          node[P+k] <= '0;
        end
      end
    end
    for (genvar i = 1; i < P; i++) begin : g_sum
      always_ff @(posedge clk) begin
        node[i] <= node[2*i] + node[2*i+1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q[0] <= in_valid;
      for (int s = 1; s <= LVL; s++) v_q[s] <= v_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    t_q[0] <= in_tag;
    for (int s = 1; s <= LVL; s++) t_q[s] <= t_q[s-1];
  end

  assign out_valid = v_q[LVL];
  assign out_tag   = t_q[LVL];
  assign out_sum   = node[1];

endmodule

// File: rtl/mm_ctrl.sv
// Phase sequencer and the shared row/column walker.
module mm_ctrl #(
  parameter int DIM = 8,
  localparam int IW = mm_pkg::idx_w(DIM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic          res_valid,
  input  logic          res_last,
  output logic          in_ready,
  output logic          a_we,
  output logic          b_we,
  output logic          iss_valid,
  output logic          out_valid,
  output logic [IW-1:0] cur_r,
  output logic [IW-1:0] cur_c,
  output logic          done,
  output logic          busy
);
  import mm_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(DIM - 1);

  phase_e        ph_q, ph_n;
  logic [IW-1:0] r_q, r_n, c_q, c_n;
  logic          iss_done_q, iss_done_n;
  logic          done_q, done_n;
  logic          step, last_pos;

  assign last_pos = (r_q == LAST) && (c_q == LAST);

  always_comb begin
    ph_n       = ph_q;
    r_n        = r_q;
    c_n        = c_q;
    iss_done_n = iss_done_q;
    done_n     = 1'b0;
    step       = 1'b0;
    in_ready   = 1'b0;
    out_valid  = 1'b0;
    iss_valid  = 1'b0;
    a_we       = 1'b0;
    b_we       = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_n = PH_LOAD_A;
          r_n  = '0;
          c_n  = '0;
        end
      end
      PH_LOAD_A: begin
        in_ready = 1'b1;
        a_we     = in_valid;
        step     = in_valid;
        if (in_valid && last_pos) ph_n = PH_LOAD_B;
      end
      PH_LOAD_B: begin
        in_ready = 1'b1;
        b_we     = in_valid;
        step     = in_valid;
        if (in_valid && last_pos) begin
          ph_n       = PH_COMPUTE;
          iss_done_n = 1'b0;
        end
      end
      PH_COMPUTE: begin
        iss_valid = !iss_done_q;
        step      = iss_valid;
        if (iss_valid && last_pos) iss_done_n = 1'b1;
        if (res_valid && res_last) ph_n = PH_STORE;
      end
      PH_STORE: begin
        out_valid = 1'b1;
        step      = out_ready;
        if (out_ready && last_pos) begin
          ph_n   = PH_IDLE;
          done_n = 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
    if (step) begin
      c_n = (c_q == LAST) ? '0 : c_q + 1'b1;
      if (c_q == LAST) r_n = (r_q == LAST) ? '0 : r_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      r_q        <= '0;
      c_q        <= '0;
      iss_done_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      ph_q       <= ph_n;
      r_q        <= r_n;
      c_q        <= c_n;
      iss_done_q <= iss_done_n;
      done_q     <= done_n;
    end
  end

  assign cur_r = r_q;
  assign cur_c = c_q;
  assign done  = done_q;
  assign busy  = (ph_q != PH_IDLE);

endmodule

// File: rtl/mat_mul_buf.sv
module mat_mul_buf #(
  parameter int DIM = 8,
  parameter int DW  = 16,
  localparam int AW = 2*DW + mm_pkg::idx_w(DIM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data,
  output logic          done,
  output logic          busy
);

  localparam int IW = mm_pkg::idx_w(DIM);
  localparam int TW = 2 * IW;
  localparam logic [IW-1:0] LAST = IW'(DIM - 1);

  logic                 a_we, b_we, iss_valid;
  logic [IW-1:0]        cur_r, cur_c;
  logic signed [DW-1:0] a_vec [DIM];
  logic signed [DW-1:0] b_vec [DIM];
  logic                 res_valid, res_last;
  logic [TW-1:0]        res_tag;
  logic signed [AW-1:0] res_sum;
  logic signed [AW-1:0] c_mem [DIM][DIM];
  logic [IW-1:0]        wr_addr;

  mm_ctrl #(.DIM(DIM)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .res_valid (res_valid),
    .res_last  (res_last),
    .in_ready  (in_ready),
    .a_we      (a_we),
    .b_we      (b_we),
    .iss_valid (iss_valid),
    .out_valid (out_valid),
    .cur_r     (cur_r),
    .cur_c     (cur_c),
    .done      (done),
    .busy      (busy)
  );

  // A[r][c] lives in bank c at address r; B[r][c] lives in bank r at address c.
  assign wr_addr = a_we ? cur_r : cur_c;

  generate
    for (genvar k = 0; k < DIM; k++) begin : g_bank
      mm_bank #(.DIM(DIM), .DW(DW)) u_bank (
        .clk     (clk),
        .a_we    (a_we && (cur_c == IW'(k))),
        .b_we    (b_we && (cur_r == IW'(k))),
        .waddr   (wr_addr),
        .wdata   (in_data),
        .a_raddr (cur_r),
        .b_raddr (cur_c),
        .a_rdata (a_vec[k]),
        .b_rdata (b_vec[k])
      );
    end
  endgenerate

  mm_adder_tree #(.DIM(DIM), .DW(DW), .AW(AW), .TW(TW)) u_tree (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (iss_valid),
    .in_tag    ({cur_r, cur_c}),
    .a_vec     (a_vec),
    .b_vec     (b_vec),
    .out_valid (res_valid),
    .out_tag   (res_tag),
    .out_sum   (res_sum)
  );

  assign res_last = (res_tag == {LAST, LAST});

  always_ff @(posedge clk) begin
    if (res_valid) c_mem[res_tag[TW-1:IW]][res_tag[IW-1:0]] <= res_sum;
  end

  assign out_data = c_mem[cur_r][cur_c];

endmodule

// File: rtl/mat_mul_buf_chk.sv
module mat_mul_buf_chk #(
  parameter int AW = 35
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_data,
  input logic          done,
  input logic          busy
);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (in_ready && busy)); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && out_valid && !out_ready) |=> (out_valid && busy)); // R9

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready) && !busy)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid)); // R7

endmodule

bind mat_mul_buf mat_mul_buf_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done),
  .busy      (busy)
);

// File: tb/mat_mul_buf_tb.sv
`timescale 1ns/1ps
module mat_mul_buf_tb;

  localparam int DIM = 8;
  localparam int DW  = 16;
  localparam int AW  = 2*DW + $clog2(DIM);
  localparam int LAT = DIM*DIM + $clog2(DIM) + 1;
  localparam int WD  = 150000;

  logic          clk = 1'b0;
  logic          rst_n, start, in_valid, out_ready;
  logic [DW-1:0] in_data;
  logic          in_ready, out_valid, done, busy;
  logic [AW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  longint ma [DIM][DIM];
  longint mb [DIM][DIM];

  always #4 clk = ~clk;

  mat_mul_buf #(.DIM(DIM), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // kind 0: mixed signs; 1: all most-negative; 2: padded n; 3: identity A
  task automatic fill(input int kind, input int n);
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        case (kind)
          0: begin ma[i][j] = ((i*5 + j*3) % 17) - 8;  mb[i][j] = ((i*3 + j*7) % 23) - 11; end
          1: begin ma[i][j] = -32768;                   mb[i][j] = -32768; end
          2: begin
               ma[i][j] = (i < n && j < n) ? ((i*9 + j*4) % 31) - 15  : 0;
               mb[i][j] = (i < n && j < n) ? 1000 - (i*250 + j*97)     : 0;
             end
          default: begin ma[i][j] = (i == j) ? 1 : 0; mb[i][j] = 30000 - (i*1111 + j*4321); end
        endcase
      end
  endtask

  task automatic send(input longint w, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'hDEAD;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(w);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic run_job(input string tag, input bit stall, input bit poke);
    int k;
    // R2: start while idle opens a load
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(in_ready && busy, "R2", {in_ready, busy}, 3);
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++)
        send(ma[i][j], (stall && ((i + j) % 3 == 0)) ? 1 : 0);
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        if (poke && i == 3 && j == 0) begin   // R9 start while loading
          @(negedge clk); in_valid = 1'b0; start = 1'b1;
          @(negedge clk); start = 1'b0;
        end
        send(mb[i][j], (stall && ((i * j) % 4 == 1)) ? 2 : 0);
      end
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R3", in_ready, 0);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!out_valid && k < 300);
    chk(k == LAT, "R5", k, LAT);
    for (int e = 0; e < DIM*DIM; e++) begin
      int r = e / DIM;
      int c = e % DIM;
      bit taken = 1'b0;
      bit held = 1'b0;
      logic [AW-1:0] hd = '0;
      longint ex = 0;
      int cnt = 0;
      for (int q = 0; q < DIM; q++) ex += ma[r][q] * mb[q][c];
      while (!taken) begin
        if (cnt > 0 || e > 0) @(negedge clk);
        start = 1'b0;
        if (held) chk(out_valid && out_data == hd, "R6", longint'(out_data), longint'(hd));
        chk(out_valid, "R4", out_valid, 1);
        out_ready = stall ? (((e + cnt) % 4) != 1) : 1'b1;
        cnt++;
        if (out_ready) begin
          chk(longint'($signed(out_data)) == ex, tag, longint'($signed(out_data)), ex);
          taken = 1'b1;
        end else begin
          held = 1'b1;
          hd   = out_data;
          if (poke && e == 10) start = 1'b1;  // R9 start while unloading
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(done && !busy, "R7", {done, busy}, 2);
    @(negedge clk);
    chk(!done && !out_valid && !in_ready, "R7", {done, out_valid, in_ready}, 0);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    chk(1'b0, "R5 watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid && !done && !busy, "R1", {in_ready, out_valid, done, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!in_ready && !out_valid && !done && !busy, "R1", {in_ready, out_valid, done, busy}, 0);

    fill(0, DIM); run_job("R4", 1'b0, 1'b0);
    fill(0, DIM); run_job("R4", 1'b1, 1'b0);
    fill(3, DIM); run_job("R4", 1'b1, 1'b0);
    fill(1, DIM); run_job("R10", 1'b0, 1'b0);
    fill(2, 5);   run_job("R8", 1'b1, 1'b0);
    fill(0, DIM); run_job("R9", 1'b1, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule